// File: doc/BRIEF.md
# Parallel Synchronous Port Handshake Engine

This block is the pin-side engine of a parallel synchronous data port. It runs on the system clock and sees the external parallel data clock only as an already synchronised sample. It turns that sample into capture and launch strobes. In receive mode it takes 8-bit or 16-bit words off the parallel bus and pushes them into a word FIFO. In transmit mode it pops words from a FIFO and drives them onto the bus. One direction bit selects the mode.

Flow control uses two side signals: a "valid" strobe, which the sender drives, and a "ready" strobe, which the receiver drives. Each strobe has its own polarity bit. A 3-bit routing code can switch each strobe on or off and move it to either of two shared pins, called pin A and pin B. The code can also put both strobes on one pin and turn that pin around between the two sides. Register decoding, DMA and clock-domain crossing live outside this block.

Top module: `pport_engine`

## Requirements
- R1: With `cfg_clk_pol`=0, input data is captured when the sampled parallel clock falls and transmit data is launched when it rises. With `cfg_clk_pol`=1, both edges swap. An edge is seen in the system cycle where `pclk_s` differs from its value in the previous cycle.
- R2: With `cfg_width`=3, all 16 bits move per edge. With any other code, only bits [7:0] move: a received word has bits [15:8] zero, and a transmitted word is driven with bits [15:8] zero.
- R3: In receive mode, `rx_push` pulses for one cycle, in the cycle after a capture edge, carrying the bus value sampled at that edge. When the valid strobe is enabled, the pulse happens only if the valid level sampled at that edge matches `cfg_de_pol` (1 means active-high).
- R4: A word is never pushed unless `rx_room` was high at the capture edge. The ready strobe is asserted in the cycle after `rx_room` is high and deasserted in the cycle after it is low. Its pin level is `cfg_rdy_pol` when asserted and the inverse when not.
- R5: In transmit mode, `tx_pop` is high in the cycle of a launch edge if `tx_avail` is high and either the ready strobe is disabled or its sampled level matches `cfg_rdy_pol`. On the next cycle the popped word is on `bus_out` and the valid strobe is asserted. A launch edge without a pop deasserts the valid strobe and leaves `bus_out` unchanged.
- R6: Routing code `cfg_hs` places the strobes as follows. 0: none. 1: ready on B. 2: valid on A. 3: valid on A and ready on B. 4: both on B, shared. 5: ready on A. 6: valid on B. 7: both on A, shared. A pin is driven (oe high) only when it carries this side's outgoing strobe: ready in receive mode, valid in transmit mode.
- R7: A strobe moved to the other pin keeps its own polarity bit. In code 5 the ready strobe on pin A uses `cfg_rdy_pol`, and in code 6 the valid strobe on pin B uses `cfg_de_pol`.
- R8: In the shared codes (4, 7), the block drives the shared pin only during the half clock period that follows its own sampling edge. In receive mode that is while the previous sample equals `cfg_clk_pol`; in transmit mode it is while the previous sample differs from it. The pin is released during the other half, so the far side's strobe can be read there.
- R9: With `cfg_en`=0, no output enable is high, `rx_push` and `tx_pop` stay low, and both strobes are deasserted.
- R10: `bus_oe` is high exactly when `cfg_en`=1 and `cfg_dir`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Engine enable |
| cfg_dir | input | 1 | 0 receive, 1 transmit |
| cfg_clk_pol | input | 1 | Active edge select |
| cfg_de_pol | input | 1 | Valid strobe active level |
| cfg_rdy_pol | input | 1 | Ready strobe active level |
| cfg_width | input | 2 | 3 selects 16-bit words, others 8-bit |
| cfg_hs | input | 3 | Strobe routing code |
| pclk_s | input | 1 | Synchronised parallel clock sample |
| bus_in | input | 16 | Parallel data bus input |
| bus_out | output | 16 | Parallel data bus output |
| bus_oe | output | 1 | Data bus output enable |
| pin_a_in | input | 1 | Pin A input level |
| pin_a_out | output | 1 | Pin A output level |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_in | input | 1 | Pin B input level |
| pin_b_out | output | 1 | Pin B output level |
| pin_b_oe | output | 1 | Pin B output enable |
| rx_push | output | 1 | Push strobe to receive FIFO |
| rx_word | output | 16 | Word pushed to receive FIFO |
| rx_room | input | 1 | Receive FIFO can take a word |
| tx_pop | output | 1 | Pop strobe to transmit FIFO |
| tx_word | input | 16 | Head word of transmit FIFO |
| tx_avail | input | 1 | Transmit FIFO holds a word |

## Verification
Two functions can land on the same system cycle in receive mode. A capture edge may arrive in the same cycle that `rx_room` falls, so the push decision and the ready strobe both change then. In the shared codes, the pin turnaround can coincide with the sampling edge. The bench provokes these cases with random FIFO levels, random strobe levels and parallel clock half-periods of one to three system cycles. A behavioural model recomputes the push, pop, pin levels and enables every cycle, and any difference is judged a failure.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int HS_W      = 3;
    localparam int WIDTH_W   = 2;
    localparam logic [WIDTH_W-1:0] WIDE_CODE = 2'd3;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef enum logic [HS_W-1:0] {
        HS_NONE     = 3'd0,
        HS_RDY      = 3'd1,
        HS_DE       = 3'd2,
        HS_BOTH     = 3'd3,
        HS_SHARE_B  = 3'd4,
        HS_RDY_ON_A = 3'd5,
        HS_DE_ON_B  = 3'd6,
        HS_SHARE_A  = 3'd7
    } hs_mode_e;

    // Strobe placement; *_on_b selects pin B, otherwise pin A
    typedef struct packed {
        logic de_on;
        logic rdy_on;
        logic de_on_b;
        logic rdy_on_b;
        logic shared;
    } route_t;

    typedef struct packed {
        logic en;
        dir_e dir;
        logic clk_pol;
        logic de_pol;
        logic rdy_pol;
        logic wide;
    } cfg_t;

    function automatic route_t decode_route(input logic [HS_W-1:0] code);
        route_t r;
        r = '0;
        case (hs_mode_e'(code))
            HS_RDY:      begin r.rdy_on = 1'b1; r.rdy_on_b = 1'b1; end
            HS_DE:       begin r.de_on = 1'b1; end
            HS_BOTH:     begin r.de_on = 1'b1; r.rdy_on = 1'b1; r.rdy_on_b = 1'b1; end
            HS_SHARE_B:  begin
                r.de_on = 1'b1; r.rdy_on = 1'b1;
                r.de_on_b = 1'b1; r.rdy_on_b = 1'b1; r.shared = 1'b1;
            end
            HS_RDY_ON_A: begin r.rdy_on = 1'b1; end
            HS_DE_ON_B:  begin r.de_on = 1'b1; r.de_on_b = 1'b1; end
            HS_SHARE_A:  begin r.de_on = 1'b1; r.rdy_on = 1'b1; r.shared = 1'b1; end
            default:     r = '0;
        endcase
        return r;
    endfunction

    function automatic logic level_of(input logic active, input logic pol);
        return active ? pol : ~pol;
    endfunction

    function automatic logic is_active(input logic level, input logic pol);
        return level == pol;
    endfunction

endpackage

// File: rtl/pport_edge.sv
module pport_edge (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clk_pol,
    input  logic pclk_s,
    output logic cap_edge,
    output logic drv_edge,
    output logic pclk_prev
);
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) pclk_prev <= 1'b0;
        else     pclk_prev <= pclk_s;
    end

    always_comb begin
        rise     = pclk_s & ~pclk_prev;
        fall     = ~pclk_s & pclk_prev;
        cap_edge = en & (clk_pol ? rise : fall);
        drv_edge = en & (clk_pol ? fall : rise);
    end
endmodule

// File: rtl/pport_rx.sv
module pport_rx #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              cap_edge,
    input  logic              wide,
    input  logic              de_on,
    input  logic              de_lvl,
    input  logic              de_pol,
    input  logic              room,
    input  logic [DATA_W-1:0] data_in,
    output logic              push,
    output logic [DATA_W-1:0] word,
    output logic              rdy_act
);
    import pport_pkg::*;
    localparam int UPPER_W = DATA_W - NARROW_W;

    logic              accept;
    logic [DATA_W-1:0] fitted;

    always_comb begin
        fitted = wide ? data_in : {{UPPER_W{1'b0}}, data_in[NARROW_W-1:0]};
        accept = active & cap_edge & room & (~de_on | is_active(de_lvl, de_pol));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push    <= 1'b0;
            word    <= '0;
            rdy_act <= 1'b0;
        end else begin
            push    <= accept;
            rdy_act <= active & room;
            if (accept) word <= fitted;
        end
    end
endmodule

// File: rtl/pport_tx.sv
module pport_tx #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              drv_edge,
    input  logic              wide,
    input  logic              rdy_on,
    input  logic              rdy_lvl,
    input  logic              rdy_pol,
    input  logic              avail,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic [DATA_W-1:0] data_out,
    output logic              de_act
);
    import pport_pkg::*;
    localparam int UPPER_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] fitted;

    always_comb begin
        fitted = wide ? head : {{UPPER_W{1'b0}}, head[NARROW_W-1:0]};
        pop    = active & drv_edge & avail & (~rdy_on | is_active(rdy_lvl, rdy_pol));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            de_act   <= 1'b0;
        end else if (!active) begin
            de_act <= 1'b0;
        end else if (drv_edge) begin
            de_act <= pop;
            if (pop) data_out <= fitted;
        end
    end
endmodule

// File: rtl/pport_pins.sv
module pport_pins (
    input  logic                  en,
    input  pport_pkg::dir_e       dir,
    input  logic                  clk_pol,
    input  logic                  de_pol,
    input  logic                  rdy_pol,
    input  pport_pkg::route_t     route,
    input  logic                  pclk_prev,
    input  logic                  de_act,
    input  logic                  rdy_act,
    input  logic [1:0]            pin_in,
    output logic [1:0]            pin_out,
    output logic [1:0]            pin_oe,
    output logic                  bus_oe,
    output logic                  de_lvl,
    output logic                  rdy_lvl
);
    import pport_pkg::*;

    logic out_on;
    logic out_on_b;
    logic out_level;
    logic own_phase;

    always_comb begin
        if (dir == DIR_TX) begin
            out_on    = route.de_on;
            out_on_b  = route.de_on_b;
            out_level = level_of(de_act, de_pol);
            own_phase = pclk_prev != clk_pol;
        end else begin
            out_on    = route.rdy_on;
            out_on_b  = route.rdy_on_b;
            out_level = level_of(rdy_act, rdy_pol);
            own_phase = pclk_prev == clk_pol;
        end
        de_lvl  = route.de_on_b  ? pin_in[1] : pin_in[0];
        rdy_lvl = route.rdy_on_b ? pin_in[1] : pin_in[0];
        bus_oe  = en & (dir == DIR_TX);
    end

    for (genvar p = 0; p < 2; p++) begin : g_pin
        assign pin_out[p] = out_level;
        assign pin_oe[p]  = en & out_on & (out_on_b == (p == 1))
                            & (~route.shared | own_phase);
    end
endmodule

// File: rtl/pport_engine.sv
module pport_engine #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_dir,
    input  logic              cfg_clk_pol,
    input  logic              cfg_de_pol,
    input  logic              cfg_rdy_pol,
    input  logic [1:0]        cfg_width,
    input  logic [2:0]        cfg_hs,
    input  logic              pclk_s,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              pin_a_in,
    output logic              pin_a_out,
    output logic              pin_a_oe,
    input  logic              pin_b_in,
    output logic              pin_b_out,
    output logic              pin_b_oe,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    input  logic              rx_room,
    output logic              tx_pop,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_avail
);
    import pport_pkg::*;

    cfg_t   cfg;
    route_t route;
    logic   cap_edge, drv_edge, pclk_prev;
    logic   de_act, rdy_act, de_lvl, rdy_lvl;
    logic [1:0] pin_in, pin_out, pin_oe;

    always_comb begin
        cfg.en      = cfg_en;
        cfg.dir     = dir_e'(cfg_dir);
        cfg.clk_pol = cfg_clk_pol;
        cfg.de_pol  = cfg_de_pol;
        cfg.rdy_pol = cfg_rdy_pol;
        cfg.wide    = cfg_width == WIDE_CODE;
        route       = decode_route(cfg_hs);
        pin_in      = {pin_b_in, pin_a_in};
    end

    pport_edge u_edge (
        .clk(clk), .rst(rst), .en(cfg.en), .clk_pol(cfg.clk_pol),
        .pclk_s(pclk_s), .cap_edge(cap_edge), .drv_edge(drv_edge),
        .pclk_prev(pclk_prev)
    );

    pport_rx #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_rx (
        .clk(clk), .rst(rst), .active(cfg.en & (cfg.dir == DIR_RX)),
        .cap_edge(cap_edge), .wide(cfg.wide), .de_on(route.de_on),
        .de_lvl(de_lvl), .de_pol(cfg.de_pol), .room(rx_room),
        .data_in(bus_in), .push(rx_push), .word(rx_word), .rdy_act(rdy_act)
    );

    pport_tx #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_tx (
        .clk(clk), .rst(rst), .active(cfg.en & (cfg.dir == DIR_TX)),
        .drv_edge(drv_edge), .wide(cfg.wide), .rdy_on(route.rdy_on),
        .rdy_lvl(rdy_lvl), .rdy_pol(cfg.rdy_pol), .avail(tx_avail),
        .head(tx_word), .pop(tx_pop), .data_out(bus_out), .de_act(de_act)
    );

    pport_pins u_pins (
        .en(cfg.en), .dir(cfg.dir), .clk_pol(cfg.clk_pol),
        .de_pol(cfg.de_pol), .rdy_pol(cfg.rdy_pol), .route(route),
        .pclk_prev(pclk_prev), .de_act(de_act), .rdy_act(rdy_act),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .bus_oe(bus_oe), .de_lvl(de_lvl), .rdy_lvl(rdy_lvl)
    );

    assign pin_a_out = pin_out[0];
    assign pin_b_out = pin_out[1];
    assign pin_a_oe  = pin_oe[0];
    assign pin_b_oe  = pin_oe[1];
endmodule

// File: rtl/pport_engine_chk.sv
module pport_engine_chk #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic              cfg_dir,
    input logic [1:0]        cfg_width,
    input logic [2:0]        cfg_hs,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic              pin_a_oe,
    input logic              pin_b_oe,
    input logic              rx_push,
    input logic [DATA_W-1:0] rx_word,
    input logic              rx_room,
    input logic              tx_pop,
    input logic              tx_avail
);
    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> $past(rx_room)); // R4

    AST_PUSH_IN_RX: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> $past(cfg_en && !cfg_dir)); // R3

    AST_POP_IN_TX: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> (cfg_en && cfg_dir && tx_avail)); // R5

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (rx_push && $past(cfg_width != 2'd3)) |-> (rx_word[DATA_W-1:NARROW_W] == '0)); // R2

    AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> !(pin_a_oe || pin_b_oe || bus_oe || tx_pop)); // R9

    AST_NO_ROUTE_NO_OE: assert property (@(posedge clk) disable iff (rst)
        (cfg_hs == 3'd0) |-> !(pin_a_oe || pin_b_oe)); // R6

    AST_BUS_OE_TX: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> cfg_dir); // R10

    AST_TX_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_dir && $past(cfg_en && cfg_dir) && !$past(tx_pop)) |-> $stable(bus_out)); // R5
endmodule

bind pport_engine pport_engine_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/tb_pport_engine.sv
module tb_pport_engine;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cfg_en = 0, cfg_dir = 0, cfg_clk_pol = 0, cfg_de_pol = 0, cfg_rdy_pol = 0;
    logic [1:0]  cfg_width = 0;
    logic [2:0]  cfg_hs = 0;
    logic        pclk_s = 0;
    logic [15:0] bus_in = 0, tx_word = 0;
    logic        pin_a_in = 0, pin_b_in = 0, rx_room = 0, tx_avail = 0;
    logic [15:0] bus_out, rx_word;
    logic        bus_oe, pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, rx_push, tx_pop;

    pport_engine dut (.*);

    int checks = 0, bad = 0, cyc = 0;
    bit done = 0;

    // behavioural model state
    logic        m_pp, m_push, m_de, m_rdy;
    logic [15:0] m_word, m_dout;
    logic [15:0] rxq[$];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void hs_map(input logic [2:0] m, output logic de_on, output logic rdy_on,
                                   output logic de_b, output logic rdy_b, output logic sh);
        de_on = 0; rdy_on = 0; de_b = 0; rdy_b = 0; sh = 0;
        case (m)
            3'd1: begin rdy_on = 1; rdy_b = 1; end
            3'd2: de_on = 1;
            3'd3: begin de_on = 1; rdy_on = 1; rdy_b = 1; end
            3'd4: begin de_on = 1; rdy_on = 1; de_b = 1; rdy_b = 1; sh = 1; end
            3'd5: rdy_on = 1;
            3'd6: begin de_on = 1; de_b = 1; end
            3'd7: begin de_on = 1; rdy_on = 1; sh = 1; end
            default: ;
        endcase
    endfunction

    function automatic logic [15:0] fit(input logic [15:0] d);
        return (cfg_width == 2'd3) ? d : {8'h00, d[7:0]};
    endfunction

    function automatic logic pop_now();
        logic de_on, rdy_on, de_b, rdy_b, sh, lvl, drv;
        hs_map(cfg_hs, de_on, rdy_on, de_b, rdy_b, sh);
        lvl = rdy_b ? pin_b_in : pin_a_in;
        drv = cfg_clk_pol ? (!pclk_s && m_pp) : (pclk_s && !m_pp);
        return cfg_en && cfg_dir && drv && tx_avail && (!rdy_on || lvl == cfg_rdy_pol);
    endfunction

    always @(posedge clk) begin
        logic de_on, rdy_on, de_b, rdy_b, sh, lvl, cap, p;
        if (rst) begin
            m_pp = 0; m_push = 0; m_de = 0; m_rdy = 0; m_word = 0; m_dout = 0;
            rxq.delete();
        end else begin
            hs_map(cfg_hs, de_on, rdy_on, de_b, rdy_b, sh);
            cap = cfg_clk_pol ? (pclk_s && !m_pp) : (!pclk_s && m_pp);
            lvl = de_b ? pin_b_in : pin_a_in;
            m_push = cfg_en && !cfg_dir && cap && rx_room && (!de_on || lvl == cfg_de_pol);
            if (m_push) begin
                m_word = fit(bus_in);
                rxq.push_back(m_word);
            end
            m_rdy = cfg_en && !cfg_dir && rx_room;
            p = pop_now();
            if (!(cfg_en && cfg_dir)) m_de = 0;
            else if (cfg_clk_pol ? (!pclk_s && m_pp) : (pclk_s && !m_pp)) begin
                m_de = p;
                if (p) m_dout = fit(tx_word);
            end
            m_pp = pclk_s;
        end
    end

    task automatic compare();
        logic de_on, rdy_on, de_b, rdy_b, sh, out_on, out_b, act, pol, phase, ea, eb, lvl;
        logic [15:0] w;
        hs_map(cfg_hs, de_on, rdy_on, de_b, rdy_b, sh);
        out_on = cfg_dir ? de_on : rdy_on;
        out_b  = cfg_dir ? de_b : rdy_b;
        act    = cfg_dir ? m_de : m_rdy;
        pol    = cfg_dir ? cfg_de_pol : cfg_rdy_pol;
        phase  = cfg_dir ? (m_pp != cfg_clk_pol) : (m_pp == cfg_clk_pol);
        ea = cfg_en && out_on && !out_b && (!sh || phase);
        eb = cfg_en && out_on && out_b && (!sh || phase);
        lvl = act ? pol : !pol;
        chk("R3", "rx_push", rx_push, m_push);
        if (rx_push && rxq.size() > 0) begin
            w = rxq.pop_front();
            chk("R2", "rx_word", rx_word, w);
        end
        chk("R5", "tx_pop", tx_pop, pop_now());
        chk("R5", "bus_out", bus_out, m_dout);
        chk("R10", "bus_oe", bus_oe, cfg_en && cfg_dir);
        chk("R6", "pin_a_oe", pin_a_oe, ea);   // R8 phase gating included
        chk("R6", "pin_b_oe", pin_b_oe, eb);
        if (ea) chk("R7", "pin_a_out", pin_a_out, lvl);
        if (eb) chk("R4", "pin_b_out", pin_b_out, lvl);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int half, cnt;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state: nothing driven, no strobes (R9)
        chk("R9", "reset pins oe", {pin_a_oe, pin_b_oe, bus_oe}, 3'b000);
        chk("R9", "reset push", {rx_push, tx_pop}, 2'b00);
        chk("R9", "reset bus_out", bus_out, 16'h0);
        for (int s = 0; s < 48; s++) begin
            // R1 both clock polarities, R6/R7/R8 every routing code, R9 disabled runs
            cfg_hs      = 3'(s % 8);
            cfg_dir     = (s / 8) % 2;
            cfg_clk_pol = (s / 16) % 2;
            cfg_de_pol  = $urandom % 2;
            cfg_rdy_pol = $urandom % 2;
            cfg_width   = ($urandom % 2) ? 2'd3 : 2'($urandom % 3);
            cfg_en      = (s < 40);
            half = 1 + (s % 3);
            cnt = 0;
            for (int c = 0; c < 240; c++) begin
                @(negedge clk);
                compare();
                cnt++;
                if (cnt >= half) begin pclk_s = !pclk_s; cnt = 0; end
                bus_in   = 16'($urandom);
                tx_word  = 16'($urandom);
                pin_a_in = $urandom % 2;
                pin_b_in = $urandom % 2;
                rx_room  = ($urandom % 4) != 0;
                tx_avail = ($urandom % 4) != 0;
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule